// File: doc/BRIEF.md
# Multi-Sector DMA Read Sequencer

This block runs a multi-sector read from start to end without help from the host. A start pulse loads a 24-bit starting block address, a 24-bit block count and an 8-bit read mode, all taken from the read packet. The block asks the media side for one sector. It waits for the media to report ready along with the sector size. It then streams that sector's buffered bytes, one per clock, to whichever DMA requester is active. When a sector runs dry and more blocks remain, the next sector is fetched on its own.

A DMA request carries a byte length and may be any size. It can cross any number of sector boundaries, and the refill happens inside the same request. A request ends in one of three ways: its length is used up, the last sector drains, or the media reports an error. When it ends, the block reports the number of bytes actually moved. The completion interrupt is raised once, after the final sector has drained, and not at each sector. A media error aborts the read and latches the error code and the failing block address.

Top module: `sector_dma_seq`

## Requirements
- R1: A start pulse accepted while idle with a non-zero count raises `media_req_o` on the next clock, with `media_lba_o` equal to the start address and `media_mode_o` equal to the start mode. While a sector is being fetched, `status_o` reads 0x80.
- R2: A good sector-ready (`media_rdy_i` high with `media_err_i` low) moves the block to streaming. On that edge the address advances by one, the remaining count drops by one, the offset returns to 0 and the sector length becomes `media_size_i`, held to at most 2352 and with 0 taken as 1. `status_o` becomes 0xD0 and `ireason_o` becomes 2. The interrupt is not raised.
- R3: While a request is open and a sector is buffered, every clock produces one beat. `dma_valid_o` is high one clock after the byte is read, and `dma_data_o` carries the media byte at offsets 0, 1, 2 … of the current sector, in order.
- R4: A request moves bytes across sector boundaries. When a sector drains and blocks remain, the next sector is fetched and streaming resumes within the same request, with no new `dma_req_i`.
- R5: When a request's length is used up, `dma_done_o` pulses for one clock on the edge after the last beat's read, and `dma_count_o` equals the requested length.
- R6: When the last sector drains, the block returns to idle. In the same clock, `status_o` becomes 0x50, `ireason_o` becomes 3 and `irq_o` rises, and the open request ends with `dma_done_o` and `dma_count_o` equal to the bytes actually moved.
- R7: A media error during a fetch aborts the read. `status_o` becomes 0x51, `ireason_o` becomes 3, `irq_o` rises, `sense_key_o` takes `media_code_i`, and `sense_lba_o` takes the address being fetched. An open request ends and reports the bytes moved so far.
- R8: A DMA request made while no read is active, or with length 0, ends on the next clock with `dma_done_o` high and `dma_count_o` equal to 0.
- R9: A start with a block count of 0 issues no media request. On the next clock it sets `status_o` to 0x50, `ireason_o` to 3 and `irq_o` to 1.
- R10: `irq_ack_i` clears `irq_o` on the next clock. An accepted start also clears it.
- R11: After reset, `status_o` is 0x00, `ireason_o` is 1, and `irq_o`, `media_req_o`, `dma_valid_o` and `dma_done_o` are all 0.
- R12: A start pulse during an active read has no effect, and so does a DMA request while another request is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a read (packet received) |
| start_lba_i | input | 24 | First block address |
| start_cnt_i | input | 24 | Number of blocks to read |
| start_mode_i | input | 8 | Read mode passed to the media |
| irq_ack_i | input | 1 | Interrupt acknowledge (status read) |
| media_req_o | output | 1 | Sector fetch request, held until ready |
| media_lba_o | output | 24 | Block address of the requested sector |
| media_mode_o | output | 8 | Read mode for the requested sector |
| media_rdy_i | input | 1 | One-clock sector-ready strobe |
| media_size_i | input | 12 | Sector size in bytes, valid with ready |
| media_err_i | input | 1 | Fetch failed, valid with ready |
| media_code_i | input | 8 | Error code, valid with ready |
| media_addr_o | output | 12 | Byte offset into the buffered sector |
| media_data_i | input | 8 | Buffered byte at `media_addr_o` |
| dma_req_i | input | 1 | DMA request strobe |
| dma_len_i | input | 16 | Requested byte count |
| dma_valid_o | output | 1 | Data beat valid |
| dma_data_o | output | 8 | Data beat byte |
| dma_done_o | output | 1 | One-clock request-finished strobe |
| dma_count_o | output | 16 | Bytes moved by the request |
| status_o | output | 8 | Device status code |
| ireason_o | output | 2 | Transfer phase code |
| irq_o | output | 1 | Completion or error interrupt |
| sense_key_o | output | 8 | Last media error code |
| sense_lba_o | output | 24 | Block address of the last media error |

## Verification
The read position lives in three places: the address and remaining-count cursor, the byte offset, and the request window counter. A wrong value in the cursor shows on `media_lba_o` at the next fetch. A wrong offset shows on `dma_data_o` within one beat, because each byte is a function of both block and offset. A slipped window or remaining count shows as a `dma_done_o` or `irq_o` that comes one or more clocks early or late. It also shows as a wrong `dma_count_o`. The bench's model follows the exact clock of every strobe, so any of these faults appears at the first clock where the ports disagree, not at the end of a transfer.

// File: rtl/sds_pkg.sv
package sds_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_XFER  = 2'd2
  } sds_state_e;

  localparam logic [7:0] STAT_RESET = 8'h00;
  localparam logic [7:0] STAT_BUSY  = 8'h80;
  localparam logic [7:0] STAT_DMA   = 8'hD0;
  localparam logic [7:0] STAT_DONE  = 8'h50;
  localparam logic [7:0] STAT_ERR   = 8'h51;

  localparam logic [1:0] IRS_RESET = 2'd1;
  localparam logic [1:0] IRS_DATA  = 2'd2;
  localparam logic [1:0] IRS_END   = 2'd3;
endpackage

// File: rtl/sds_cursor.sv
module sds_cursor #(
  parameter int LBA_W      = 24,
  parameter int CNT_W      = 24,
  parameter int SIZE_W     = 12,
  parameter int MAX_SECTOR = 2352
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [LBA_W-1:0]  load_lba_i,
  input  logic [CNT_W-1:0]  load_cnt_i,
  input  logic              fetch_ok_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              step_i,
  output logic [LBA_W-1:0]  lba_o,
  output logic              none_left_o,
  output logic [SIZE_W-1:0] off_o,
  output logic              drain_o
);
  localparam logic [SIZE_W-1:0] MAX_LEN  = SIZE_W'(MAX_SECTOR);
  localparam logic [SIZE_W-1:0] ONE_B    = SIZE_W'(1);
  localparam logic [LBA_W-1:0]  ONE_LBA  = LBA_W'(1);
  localparam logic [CNT_W-1:0]  ONE_CNT  = CNT_W'(1);

  logic [LBA_W-1:0]  lba_q, lba_n;
  logic [CNT_W-1:0]  left_q, left_n;
  logic [SIZE_W-1:0] off_q, off_n;
  logic [SIZE_W-1:0] len_q, len_n;
  logic [SIZE_W-1:0] size_clip;

  always_comb begin
    if (size_i > MAX_LEN)       size_clip = MAX_LEN;
    else if (size_i == '0)      size_clip = ONE_B;
    else                        size_clip = size_i;
  end

  always_comb begin
    lba_n  = lba_q;
    left_n = left_q;
    off_n  = off_q;
    len_n  = len_q;
    if (load_i) begin
      lba_n  = load_lba_i;
      left_n = load_cnt_i;
    end else if (fetch_ok_i) begin
      lba_n  = lba_q + ONE_LBA;
      left_n = left_q - ONE_CNT;
      off_n  = '0;
      len_n  = size_clip;
    end else if (step_i) begin
      off_n  = off_q + ONE_B;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lba_q  <= '0;
      left_q <= '0;
      off_q  <= '0;
      len_q  <= '0;
    end else begin
      lba_q  <= lba_n;
      left_q <= left_n;
      off_q  <= off_n;
      len_q  <= len_n;
    end
  end

  assign lba_o       = lba_q;
  assign none_left_o = (left_q == '0);
  assign off_o       = off_q;
  assign drain_o     = ((off_q + ONE_B) == len_q);

  // R3: a beat is only ever taken from inside the buffered sector
  p_off_in_sector_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> (off_q < len_q));

  // R2: a good fetch restarts the offset at zero
  p_fetch_rewind_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_ok_i && !load_i) |=> (off_o == '0));
endmodule

// File: rtl/sds_window.sv
module sds_window #(
  parameter int XFER_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              open_i,
  input  logic [XFER_W-1:0] open_len_i,
  input  logic              zero_i,
  input  logic              step_i,
  input  logic              close_i,
  output logic              act_o,
  output logic              last_o,
  output logic [XFER_W-1:0] xfer_o
);
  localparam logic [XFER_W-1:0] ONE_X = XFER_W'(1);

  logic              act_q, act_n;
  logic [XFER_W-1:0] rem_q, rem_n;
  logic [XFER_W-1:0] cnt_q, cnt_n;

  always_comb begin
    act_n = act_q;
    rem_n = rem_q;
    cnt_n = cnt_q;
    if (close_i)     act_n = 1'b0;
    else if (open_i) act_n = 1'b1;
    if (open_i) begin
      rem_n = open_len_i;
      cnt_n = '0;
    end else if (zero_i) begin
      cnt_n = '0;
    end else if (step_i) begin
      rem_n = rem_q - ONE_X;
      cnt_n = cnt_q + ONE_X;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      rem_q <= '0;
      cnt_q <= '0;
    end else begin
      act_q <= act_n;
      rem_q <= rem_n;
      cnt_q <= cnt_n;
    end
  end

  assign act_o  = act_q;
  assign last_o = (rem_q == ONE_X);
  assign xfer_o = cnt_q;

  // R5: bytes only move inside an open request
  p_step_in_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> act_q);

  // R5: the beat that uses up the length must close the request
  p_close_on_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && last_o) |-> close_i);
endmodule

// File: rtl/sector_dma_seq.sv
module sector_dma_seq
  import sds_pkg::*;
#(
  parameter int LBA_W      = 24,
  parameter int CNT_W      = 24,
  parameter int SIZE_W     = 12,
  parameter int XFER_W     = 16,
  parameter int MAX_SECTOR = 2352
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [LBA_W-1:0]  start_lba_i,
  input  logic [CNT_W-1:0]  start_cnt_i,
  input  logic [7:0]        start_mode_i,
  input  logic              irq_ack_i,
  output logic              media_req_o,
  output logic [LBA_W-1:0]  media_lba_o,
  output logic [7:0]        media_mode_o,
  input  logic              media_rdy_i,
  input  logic [SIZE_W-1:0] media_size_i,
  input  logic              media_err_i,
  input  logic [7:0]        media_code_i,
  output logic [SIZE_W-1:0] media_addr_o,
  input  logic [7:0]        media_data_i,
  input  logic              dma_req_i,
  input  logic [XFER_W-1:0] dma_len_i,
  output logic              dma_valid_o,
  output logic [7:0]        dma_data_o,
  output logic              dma_done_o,
  output logic [XFER_W-1:0] dma_count_o,
  output logic [7:0]        status_o,
  output logic [1:0]        ireason_o,
  output logic              irq_o,
  output logic [7:0]        sense_key_o,
  output logic [LBA_W-1:0]  sense_lba_o
);
  sds_state_e        st_q, st_n;
  logic [7:0]        status_q, status_n;
  logic [1:0]        irs_q, irs_n;
  logic              irq_q, irq_n;
  logic [7:0]        skey_q, skey_n;
  logic [LBA_W-1:0]  slba_q, slba_n;
  logic [7:0]        mode_q, mode_n;
  logic              beat_q, beat_n;
  logic [7:0]        data_q, data_n;
  logic              done_q, done_n;

  logic [LBA_W-1:0]  cur_lba;
  logic              none_left, drain;
  logic [SIZE_W-1:0] cur_off;
  logic              win_act, win_last;
  logic [XFER_W-1:0] win_cnt;

  logic start_ok, cnt_zero, fetch_ok, fetch_bad, step, final_beat, refill;
  logic close, try_req, reject, open;

  assign cnt_zero   = (start_cnt_i == '0);
  assign start_ok   = start_i && (st_q == ST_IDLE);
  assign fetch_ok   = (st_q == ST_FETCH) && media_rdy_i && !media_err_i;
  assign fetch_bad  = (st_q == ST_FETCH) && media_rdy_i && media_err_i;
  assign step       = (st_q == ST_XFER) && win_act;
  assign final_beat = step && drain && none_left;
  assign refill     = step && drain && !none_left;

  always_comb begin
    st_n     = st_q;
    status_n = status_q;
    irs_n    = irs_q;
    irq_n    = irq_q;
    skey_n   = skey_q;
    slba_n   = slba_q;
    mode_n   = mode_q;
    if (irq_ack_i) irq_n = 1'b0;
    if (start_ok) begin
      irq_n = 1'b0;
      if (cnt_zero) begin
        status_n = STAT_DONE;
        irs_n    = IRS_END;
        irq_n    = 1'b1;
      end else begin
        st_n     = ST_FETCH;
        status_n = STAT_BUSY;
        mode_n   = start_mode_i;
      end
    end
    if (fetch_ok) begin
      st_n     = ST_XFER;
      status_n = STAT_DMA;
      irs_n    = IRS_DATA;
    end
    if (fetch_bad) begin
      st_n     = ST_IDLE;
      status_n = STAT_ERR;
      irs_n    = IRS_END;
      irq_n    = 1'b1;
      skey_n   = media_code_i;
      slba_n   = cur_lba;
    end
    if (refill) begin
      st_n     = ST_FETCH;
      status_n = STAT_BUSY;
    end
    if (final_beat) begin
      st_n     = ST_IDLE;
      status_n = STAT_DONE;
      irs_n    = IRS_END;
      irq_n    = 1'b1;
    end
  end

  always_comb begin
    close   = (step && (win_last || final_beat)) || (fetch_bad && win_act);
    try_req = dma_req_i && !win_act;
    reject  = try_req && ((st_n == ST_IDLE) || (dma_len_i == '0));
    open    = try_req && !reject;
    done_n  = close || reject;
    beat_n  = step;
    data_n  = step ? media_data_i : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      status_q <= STAT_RESET;
      irs_q    <= IRS_RESET;
      irq_q    <= 1'b0;
      skey_q   <= '0;
      slba_q   <= '0;
      mode_q   <= '0;
      beat_q   <= 1'b0;
      data_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      st_q     <= st_n;
      status_q <= status_n;
      irs_q    <= irs_n;
      irq_q    <= irq_n;
      skey_q   <= skey_n;
      slba_q   <= slba_n;
      mode_q   <= mode_n;
      beat_q   <= beat_n;
      data_q   <= data_n;
      done_q   <= done_n;
    end
  end

  sds_cursor #(
    .LBA_W(LBA_W), .CNT_W(CNT_W), .SIZE_W(SIZE_W), .MAX_SECTOR(MAX_SECTOR)
  ) u_cursor (
    .clk(clk), .rst_n(rst_n),
    .load_i(start_ok && !cnt_zero), .load_lba_i(start_lba_i), .load_cnt_i(start_cnt_i),
    .fetch_ok_i(fetch_ok), .size_i(media_size_i), .step_i(step),
    .lba_o(cur_lba), .none_left_o(none_left), .off_o(cur_off), .drain_o(drain)
  );

  sds_window #(.XFER_W(XFER_W)) u_window (
    .clk(clk), .rst_n(rst_n),
    .open_i(open), .open_len_i(dma_len_i), .zero_i(reject),
    .step_i(step), .close_i(close),
    .act_o(win_act), .last_o(win_last), .xfer_o(win_cnt)
  );

  assign media_req_o  = (st_q == ST_FETCH);
  assign media_lba_o  = cur_lba;
  assign media_mode_o = mode_q;
  assign media_addr_o = cur_off;
  assign dma_valid_o  = beat_q;
  assign dma_data_o   = data_q;
  assign dma_done_o   = done_q;
  assign dma_count_o  = win_cnt;
  assign status_o     = status_q;
  assign ireason_o    = irs_q;
  assign irq_o        = irq_q;
  assign sense_key_o  = skey_q;
  assign sense_lba_o  = slba_q;

  // R2: entering the DMA phase never raises the interrupt
  p_dma_phase_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_ok && !irq_q) |=> (!irq_o && status_o == STAT_DMA && ireason_o == IRS_DATA));

  // R6: draining the last sector ends the read with an interrupt
  p_final_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_XFER) && win_act && drain && none_left) |=> (irq_o && status_o == STAT_DONE && dma_done_o));

  // R7: a media error latches the failing address
  p_err_sense_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_bad |=> (status_o == STAT_ERR && sense_lba_o == $past(cur_lba)));

  // R8: a request with no read behind it returns zero bytes
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req_i && !win_act && (st_q == ST_IDLE) && !start_i) |=> (dma_done_o && dma_count_o == '0));
endmodule

// File: tb/tb_sector_dma_seq.sv
`timescale 1ns/1ps
module tb_sector_dma_seq;
  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [23:0] start_lba_i;
  logic [23:0] start_cnt_i;
  logic [7:0]  start_mode_i;
  logic        irq_ack_i;
  logic        media_req_o;
  logic [23:0] media_lba_o;
  logic [7:0]  media_mode_o;
  logic        media_rdy_i;
  logic [11:0] media_size_i;
  logic        media_err_i;
  logic [7:0]  media_code_i;
  logic [11:0] media_addr_o;
  logic [7:0]  media_data_i;
  logic        dma_req_i;
  logic [15:0] dma_len_i;
  logic        dma_valid_o;
  logic [7:0]  dma_data_o;
  logic        dma_done_o;
  logic [15:0] dma_count_o;
  logic [7:0]  status_o;
  logic [1:0]  ireason_o;
  logic        irq_o;
  logic [7:0]  sense_key_o;
  logic [23:0] sense_lba_o;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  sector_dma_seq dut (
    .clk(clk), .rst_n(rst_n),
    .start_i(start_i), .start_lba_i(start_lba_i), .start_cnt_i(start_cnt_i),
    .start_mode_i(start_mode_i), .irq_ack_i(irq_ack_i),
    .media_req_o(media_req_o), .media_lba_o(media_lba_o), .media_mode_o(media_mode_o),
    .media_rdy_i(media_rdy_i), .media_size_i(media_size_i), .media_err_i(media_err_i),
    .media_code_i(media_code_i), .media_addr_o(media_addr_o), .media_data_i(media_data_i),
    .dma_req_i(dma_req_i), .dma_len_i(dma_len_i), .dma_valid_o(dma_valid_o),
    .dma_data_o(dma_data_o), .dma_done_o(dma_done_o), .dma_count_o(dma_count_o),
    .status_o(status_o), .ireason_o(ireason_o), .irq_o(irq_o),
    .sense_key_o(sense_key_o), .sense_lba_o(sense_lba_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [7:0] pat(input int tag, input int off);
    return 8'(tag * 13 + off * 7 + 5);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // ---------------- media model ----------------
  int          sec_size = 16;
  int          err_lba  = -1;
  int          wait_cnt = 0;
  logic [23:0] sec_tag  = '0;
  assign media_data_i = pat(int'(sec_tag), int'(media_addr_o));

  always @(negedge clk) begin
    if (media_rdy_i) begin
      media_rdy_i = 1'b0;
      media_err_i = 1'b0;
    end else if (rst_n && media_req_o) begin
      if (wait_cnt == 2) begin
        wait_cnt     = 0;
        media_rdy_i  = 1'b1;
        media_size_i = 12'(sec_size);
        media_err_i  = (int'(media_lba_o) == err_lba);
        sec_tag      = media_lba_o;
      end else begin
        wait_cnt++;
      end
    end
  end

  // ---------------- reference model ----------------
  int m_st, m_lba, m_left, m_off, m_len, m_mode, m_rleft, m_xfer;
  int m_status, m_irs, m_skey, m_slba, m_data, m_tag;
  bit m_act, m_irq, m_beat, m_done;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_lba = 0; m_left = 0; m_off = 0; m_len = 0; m_mode = 0;
      m_rleft = 0; m_xfer = 0; m_status = 8'h00; m_irs = 1; m_skey = 0; m_slba = 0;
      m_data = 0; m_tag = 0; m_act = 0; m_irq = 0; m_beat = 0; m_done = 0;
    end else begin
      bit stp, drn, fin, refl, ok, bad, sok, cls, oa;
      int nst;
      oa   = m_act;
      stp  = (m_st == 2) && m_act;
      drn  = stp && (m_off + 1 == m_len);
      fin  = drn && (m_left == 0);
      refl = drn && (m_left != 0);
      ok   = (m_st == 1) && media_rdy_i && !media_err_i;
      bad  = (m_st == 1) && media_rdy_i && media_err_i;
      sok  = start_i && (m_st == 0);
      cls  = (stp && (m_rleft == 1 || fin)) || (bad && m_act);
      nst  = m_st;
      m_beat = 0;
      m_done = 0;
      if (irq_ack_i) m_irq = 0;
      if (stp) begin
        m_beat = 1;
        m_data = pat(m_tag, m_off);
      end
      if (sok) begin
        m_irq = 0;
        if (start_cnt_i == 0) begin
          m_status = 8'h50; m_irs = 3; m_irq = 1;
        end else begin
          nst = 1; m_lba = start_lba_i; m_left = start_cnt_i;
          m_mode = start_mode_i; m_status = 8'h80;
        end
      end
      if (ok) begin
        nst = 2; m_tag = m_lba; m_lba = (m_lba + 1) & 24'hFFFFFF; m_left = m_left - 1;
        m_off = 0;
        m_len = (media_size_i > 2352) ? 2352 : ((media_size_i == 0) ? 1 : int'(media_size_i));
        m_status = 8'hD0; m_irs = 2;
      end
      if (bad) begin
        nst = 0; m_status = 8'h51; m_irs = 3; m_irq = 1;
        m_skey = media_code_i; m_slba = m_lba;
      end
      if (stp) begin
        m_off++; m_rleft--; m_xfer++;
      end
      if (refl) begin nst = 1; m_status = 8'h80; end
      if (fin)  begin nst = 0; m_status = 8'h50; m_irs = 3; m_irq = 1; end
      if (cls)  begin m_act = 0; m_done = 1; end
      if (dma_req_i && !oa) begin
        if (nst == 0 || dma_len_i == 0) begin
          m_done = 1; m_xfer = 0;
        end else begin
          m_act = 1; m_rleft = dma_len_i; m_xfer = 0;
        end
      end
      m_st = nst;
    end
  end

  // ---------------- per-clock comparison ----------------
  always @(negedge clk) begin
    if (rst_n) begin
      chk(status_o == 8'(m_status) && ireason_o == 2'(m_irs), "R2 status/phase",
          {status_o, 6'd0, ireason_o}, {8'(m_status), 6'd0, 2'(m_irs)});
      chk(media_req_o == (m_st == 1) &&
          (m_st != 1 || (media_lba_o == 24'(m_lba) && media_mode_o == 8'(m_mode))),
          "R1 media request", {media_req_o, media_lba_o}, {(m_st == 1), 24'(m_lba)});
      chk(dma_valid_o == m_beat && (!m_beat || dma_data_o == 8'(m_data)), "R3 beat",
          {dma_valid_o, dma_data_o}, {m_beat, 8'(m_data)});
      chk(dma_done_o == m_done && (!m_done || dma_count_o == 16'(m_xfer)), "R5 done/count",
          {dma_done_o, dma_count_o}, {m_done, 16'(m_xfer)});
      chk(irq_o == m_irq, "R6 irq", irq_o, m_irq);
      chk(sense_key_o == 8'(m_skey) && sense_lba_o == 24'(m_slba), "R7 sense",
          {sense_key_o, sense_lba_o}, {8'(m_skey), 24'(m_slba)});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic do_start(input int lba, input int cnt, input int mode);
    @(negedge clk);
    start_i = 1'b1; start_lba_i = 24'(lba); start_cnt_i = 24'(cnt); start_mode_i = 8'(mode);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic do_req(input int len);
    @(negedge clk);
    dma_req_i = 1'b1; dma_len_i = 16'(len);
    @(negedge clk);
    dma_req_i = 1'b0;
  endtask

  task automatic wait_done(output int n);
    int guard = 0;
    while (!dma_done_o && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    n = int'(dma_count_o);
    @(negedge clk);
  endtask

  task automatic req_expect(input int len, input int exp, input string req);
    int n;
    do_req(len);
    wait_done(n);
    chk(n == exp, req, n, exp);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start_i = 0; start_lba_i = 0; start_cnt_i = 0; start_mode_i = 0;
    irq_ack_i = 0; media_rdy_i = 0; media_size_i = 0; media_err_i = 0;
    media_code_i = 8'h3A; dma_req_i = 0; dma_len_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(status_o == 8'h00 && ireason_o == 2'd1 && !irq_o && !media_req_o && !dma_valid_o && !dma_done_o,
        "R11 reset state", {status_o, ireason_o, irq_o}, {8'h00, 2'd1, 1'b0});

    // R8 request with no read active
    req_expect(10, 0, "R8 idle request");

    // R9 zero-count start, then R10 acknowledge
    do_start(24'h000777, 0, 8'h28);
    chk(status_o == 8'h50 && ireason_o == 2'd3 && irq_o && !media_req_o, "R9 zero count",
        {status_o, irq_o}, {8'h50, 1'b1});
    @(negedge clk); irq_ack_i = 1'b1;
    @(negedge clk); irq_ack_i = 1'b0;
    chk(!irq_o, "R10 acknowledge", irq_o, 0);

    // R1 / R4 / R6: three sectors of 16 bytes
    sec_size = 16;
    do_start(24'h0A0B0C, 3, 8'h28);
    chk(media_req_o && media_lba_o == 24'h0A0B0C && media_mode_o == 8'h28, "R1 fetch address",
        media_lba_o, 24'h0A0B0C);
    req_expect(40, 40, "R4 request spans sectors");
    req_expect(100, 8, "R6 completion ends request early");
    chk(status_o == 8'h50 && ireason_o == 2'd3 && irq_o, "R6 completion status",
        {status_o, ireason_o, irq_o}, {8'h50, 2'd3, 1'b1});

    // R10 start clears a pending interrupt; R5 short requests
    sec_size = 5;
    do_start(24'h000040, 1, 8'h20);
    chk(!irq_o, "R10 start clears irq", irq_o, 0);
    req_expect(2, 2, "R5 length reached");
    req_expect(2, 2, "R5 length reached again");
    req_expect(2, 1, "R6 last byte only");

    // R2 size clamp, R12 ignored start, R8 zero length
    sec_size = 3000;
    do_start(24'h000200, 2, 8'h28);
    do_start(24'h000999, 7, 8'h11);
    req_expect(0, 0, "R8 zero length");
    req_expect(65535, 4704, "R2 R12 clamp and ignored start");

    // R7 media error on the third block
    sec_size = 10;
    err_lba  = 24'h000302;
    do_start(24'h000300, 4, 8'h28);
    req_expect(50, 20, "R7 error truncates request");
    chk(status_o == 8'h51 && irq_o && sense_lba_o == 24'h000302 && sense_key_o == 8'h3A,
        "R7 error sense", {status_o, sense_lba_o}, {8'h51, 24'h000302});
    err_lba = -1;

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule